// File: doc/BRIEF.md
# Programmable-Modulus Up/Down Loop Counter

This block is the loop-filter counter of an all-digital phase-locked loop. A fast counting clock steps a binary counter up or down, and a direction input chooses the way. In a loop, the phase detector output normally drives that direction input. Each time the count runs off the top of its range while rising, the block emits a single-cycle carry pulse. Each time it runs below zero while falling, it emits a single-cycle borrow pulse. A downstream pulse add/delete stage uses these pulses to pull the loop frequency.

The span of the counter is a power of two, chosen at run time by a 4-bit code. A short span gives a wide capture range and fast lock. A long span gives a narrow bandwidth. The code may be changed while the counter runs. On every step the count is first folded into the active low-order bits, so wrap detection always matches the span now selected. The all-zero code parks the counter. A count-enable input gates stepping. An asynchronous power-on reset and a synchronous clear both return the counter to zero.

Top module: `kloop_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry` and `borrow` are 0, without waiting for a clock edge.
- R2: When `clr` is high at a rising edge, `count` becomes 0 and neither pulse is raised, even if a wrap would otherwise occur.
- R3: A nonzero `mod_sel` value c selects a span of 2^(c+2) states: code 1 gives 8 and code 15 gives 131072. The count then ranges over 0 to 2^(c+2)-1.
- R4: With `en` high, `dn` low (0 means count up) and a nonzero code, each rising edge adds one to the count.
- R5: With `en` high, `dn` high (1 means count down) and a nonzero code, each rising edge subtracts one from the count.
- R6: Counting up from the top value of the span returns `count` to 0 and raises `carry` for that one cycle.
- R7: Counting down from 0 sets `count` to the top value of the span and raises `borrow` for that one cycle.
- R8: With `mod_sel` equal to 0, the count holds and no carry or borrow is produced.
- R9: With `en` low, the count holds and no carry or borrow is produced.
- R10: After a code change, the next step works on the count masked to the new span: the result is ((count AND (span-1)) ± 1) AND (span-1). A carry or borrow is raised when the masked value is at the corresponding end of the span.
- R11: `carry` and `borrow` are never high together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr | input | 1 | Synchronous clear, overrides counting |
| en | input | 1 | Count enable |
| dn | input | 1 | Direction: 0 up, 1 down |
| mod_sel | input | 4 | Span code, 0 parks the counter |
| count | output | 17 | Present count value |
| carry | output | 1 | One-cycle pulse on an upward wrap |
| borrow | output | 1 | One-cycle pulse on a downward wrap |

## Verification
Each control value sampled at a rising edge first shows on `count`, `carry` and `borrow` right after that same edge, because a single register stage sits between the inputs and the outputs. The only exception is `rst_n`, which acts at once. The bench drives every input on a falling edge and compares outputs on the next falling edge, exactly one rising edge later. Reset is checked a short delay after `rst_n` falls, with no clock edge in between. Table vectors chain one edge at a time, so each expected count follows from the previous one.

// File: rtl/kctr_pkg.sv
package kctr_pkg;

    localparam int unsigned KCTR_CNT_W   = 17;
    localparam int unsigned KCTR_SEL_W   = 4;
    // code c selects a span of 2^(c + KCTR_EXP_OFS)
    localparam int unsigned KCTR_EXP_OFS = 2;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } kdir_e;

endpackage

// File: rtl/kctr_span_dec.sv
module kctr_span_dec #(
    parameter int unsigned CNT_W   = kctr_pkg::KCTR_CNT_W,
    parameter int unsigned SEL_W   = kctr_pkg::KCTR_SEL_W,
    parameter int unsigned EXP_OFS = kctr_pkg::KCTR_EXP_OFS
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] span_mask,
    output logic             live
);

    localparam int unsigned SEL_MAX = (1 << SEL_W) - 1;

    assign live = |sel;

    // bit g belongs to the span when g < code + EXP_OFS
    for (genvar g = 0; g < int'(CNT_W); g++) begin : g_mask
        assign span_mask[g] = live &&
                              (32'(g) < (32'(sel) + 32'(EXP_OFS)));
    end

    initial begin
        if (SEL_MAX + EXP_OFS > CNT_W)
            $display("kctr_span_dec: largest span exceeds counter width");
    end

endmodule

// File: rtl/kctr_step.sv
module kctr_step #(
    parameter int unsigned CNT_W = kctr_pkg::KCTR_CNT_W
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] span_mask,
    input  kctr_pkg::kdir_e  dir,
    output logic [CNT_W-1:0] nxt,
    output logic             at_top,
    output logic             at_floor
);

    logic [CNT_W-1:0] folded;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] dec;

    always_comb begin
        folded   = cur & span_mask;
        inc      = (folded + CNT_W'(1)) & span_mask;
        dec      = (folded - CNT_W'(1)) & span_mask;
        at_top   = (folded == span_mask);
        at_floor = (folded == '0);
        nxt      = (dir == kctr_pkg::DIR_DOWN) ? dec : inc;
    end

endmodule

// File: rtl/kloop_counter.sv
module kloop_counter #(
    parameter int unsigned CNT_W   = kctr_pkg::KCTR_CNT_W,
    parameter int unsigned SEL_W   = kctr_pkg::KCTR_SEL_W,
    parameter int unsigned EXP_OFS = kctr_pkg::KCTR_EXP_OFS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             dn,
    input  logic [SEL_W-1:0] mod_sel,
    output logic [CNT_W-1:0] count,
    output logic             carry,
    output logic             borrow
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cy;
        logic             bw;
    } kstate_t;

    kstate_t          st_d;
    kstate_t          st_q;
    logic [CNT_W-1:0] span_mask;
    logic             span_live;
    logic [CNT_W-1:0] step_nxt;
    logic             step_top;
    logic             step_floor;
    kctr_pkg::kdir_e  dir;

    assign dir = dn ? kctr_pkg::DIR_DOWN : kctr_pkg::DIR_UP;

    kctr_span_dec #(
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W),
        .EXP_OFS(EXP_OFS)
    ) u_dec (
        .sel      (mod_sel),
        .span_mask(span_mask),
        .live     (span_live)
    );

    kctr_step #(
        .CNT_W(CNT_W)
    ) u_step (
        .cur      (st_q.cnt),
        .span_mask(span_mask),
        .dir      (dir),
        .nxt      (step_nxt),
        .at_top   (step_top),
        .at_floor (step_floor)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cy = 1'b0;
        st_d.bw = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (en && span_live) begin
            st_d.cnt = step_nxt;
            st_d.cy  = (dir == kctr_pkg::DIR_UP)   && step_top;
            st_d.bw  = (dir == kctr_pkg::DIR_DOWN) && step_floor;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count  = st_q.cnt;
    assign carry  = st_q.cy;
    assign borrow = st_q.bw;

endmodule

// File: rtl/kloop_counter_chk.sv
module kloop_counter_chk #(
    parameter int unsigned CNT_W = kctr_pkg::KCTR_CNT_W,
    parameter int unsigned SEL_W = kctr_pkg::KCTR_SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             en,
    input logic             dn,
    input logic [SEL_W-1:0] mod_sel,
    input logic [CNT_W-1:0] count,
    input logic             carry,
    input logic             borrow
);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |-> (count == '0) && !carry && !borrow);

    p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && !carry && !borrow);

    p_carry_lands_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (count == '0) && !$past(dn));

    p_borrow_from_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |-> $past(dn) && (count != '0));

    p_parked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel == '0 && !clr) |=> $stable(count) && !carry && !borrow);

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count) && !carry && !borrow);

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry && borrow));

    p_carry_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);

    p_borrow_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |=> !borrow);

endmodule

bind kloop_counter kloop_counter_chk #(
    .CNT_W(CNT_W),
    .SEL_W(SEL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (en),
    .dn     (dn),
    .mod_sel(mod_sel),
    .count  (count),
    .carry  (carry),
    .borrow (borrow)
);

// File: tb/sim_kloop_counter.sv
module sim_kloop_counter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr;
    logic        en;
    logic        dn;
    logic [3:0]  mod_sel;
    logic [16:0] count;
    logic        carry;
    logic        borrow;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    kloop_counter u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (en),
        .dn     (dn),
        .mod_sel(mod_sel),
        .count  (count),
        .carry  (carry),
        .borrow (borrow)
    );

    // fields: [25] clr [24] en [23] dn [22:19] code [18:2] count [1] carry [0] borrow
    localparam int NV = 22;
    localparam logic [25:0] VEC [0:NV-1] = '{
        {1'b0,1'b1,1'b0,4'd1,17'd1,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd2,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd3,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd4,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd5,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd6,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd7,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd0,1'b1,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd1,1'b0,1'b0},
        {1'b0,1'b1,1'b1,4'd1,17'd0,1'b0,1'b0},
        {1'b0,1'b1,1'b1,4'd1,17'd7,1'b0,1'b1},
        {1'b0,1'b1,1'b1,4'd1,17'd6,1'b0,1'b0},
        {1'b0,1'b0,1'b1,4'd1,17'd6,1'b0,1'b0},
        {1'b0,1'b0,1'b0,4'd1,17'd6,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd0,17'd6,1'b0,1'b0},
        {1'b0,1'b1,1'b1,4'd0,17'd6,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd2,17'd7,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd2,17'd8,1'b0,1'b0},
        {1'b0,1'b1,1'b0,4'd1,17'd1,1'b0,1'b0},
        {1'b0,1'b1,1'b1,4'd1,17'd0,1'b0,1'b0},
        {1'b0,1'b1,1'b1,4'd1,17'd7,1'b0,1'b1},
        {1'b1,1'b1,1'b0,4'd1,17'd0,1'b0,1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            7:       return "R6 carry on up wrap";
            8:       return "R11 carry one cycle";
            9, 11:   return "R5 count down";
            19:      return "R5 count down after shrink";
            10, 20:  return "R7 borrow on down wrap";
            12, 13:  return "R9 enable low holds";
            14, 15:  return "R8 code zero parks";
            16, 17:  return "R3 span of code 2";
            18:      return "R10 live shrink masks count";
            21:      return "R2 clear beats carry";
            default: return "R4 count up";
        endcase
    endfunction

    task automatic check(string tag, logic [16:0] exp_cnt, logic exp_cy, logic exp_bw);
        applied++;
        if (count !== exp_cnt || carry !== exp_cy || borrow !== exp_bw) begin
            errors++;
            $display("FAIL %s: count=%0d carry=%b borrow=%b expected count=%0d carry=%b borrow=%b",
                     tag, count, carry, borrow, exp_cnt, exp_cy, exp_bw);
        end
    endtask

    task automatic step(logic c, logic e, logic d, logic [3:0] s);
        clr = c; en = e; dn = d; mod_sel = s;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b0; en = 1'b0; dn = 1'b0; mod_sel = 4'd0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", 17'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22:19]);
            check(tag_of(i), VEC[i][18:2], VEC[i][1], VEC[i][0]);
        end

        // longest span: 0 down wraps to 2^17-1
        step(1'b0, 1'b1, 1'b1, 4'd15);
        check("R3 R7 borrow at code 15", 17'd131071, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1, 4'd15);
        check("R5 down at code 15", 17'd131070, 1'b0, 1'b0);
        // shrink to span 8: 131070 & 7 = 6 -> 7, then top -> carry
        step(1'b0, 1'b1, 1'b0, 4'd1);
        check("R10 shrink then up", 17'd7, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 4'd1);
        check("R10 R6 carry after shrink", 17'd0, 1'b1, 1'b0);
        // widen back: count keeps counting from 0
        step(1'b0, 1'b1, 1'b0, 4'd15);
        check("R4 up after widen", 17'd1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 4'd15);
        check("R4 up at code 15", 17'd2, 1'b0, 1'b0);

        // asynchronous reset with no clock edge
        en = 1'b0;
        #1 rst_n = 1'b0;
        #0.5;
        check("R1 async reset", 17'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 4'd3);
        check("R7 borrow code 3 after reset", 17'd31, 1'b0, 1'b1);

        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

endmodule